// File: doc/BRIEF.md
# Sector-Addressed Disk Byte Mover

This block is a small direct-memory-access engine. It copies a run of bytes between a simulated disk and a RAM with an 8-bit address space. It can copy in either direction: download takes bytes from the disk into RAM, and upload takes bytes from RAM onto the disk. The disk location has four parts: a head, a track, a sector and a block within the sector. The engine reads the disk and RAM data combinationally, and exactly one byte crosses in each busy clock cycle.

A host sets up the transfer in four steps:
1. Present the disk location, the RAM base address, the byte count and the direction.
2. Pulse `start`.
3. Watch the busy flag for the chosen direction.
4. Wait for `done`.

Only the block number and the RAM address advance. A transfer that runs past the last block of a sector folds back to block 0 of the same sector. A master clear input forces the engine idle.

Top module: `sector_dma`

## Requirements
- R1: After `rst`, and in the first cycle after it, `busy_down`, `busy_up`, `done` and all four strobes are 0.
- R2: Download (`dir_up` = 0). For each of the N bytes, `disk_rd` and `ram_wr` are 1 and `disk_wr` and `ram_rd` are 0. Byte i lands at RAM address base+i and comes from block start+i of the given head, track and sector.
- R3: Upload (`dir_up` = 1). For each byte, `ram_rd` and `disk_wr` are 1 and `disk_rd` and `ram_wr` are 0. Byte i goes from RAM base+i to block start+i.
- R4: The busy flag for the selected direction is 1 from the first clock edge after an accepted start, for exactly N cycles. On the edge that ends the transfer, busy falls and `done` rises.
- R5: The block number and the RAM address each step up by one per transferred byte. The RAM address wraps modulo 256.
- R6: The 4-bit block field wraps from 15 to 0. Head, track and sector never change during a transfer.
- R7: A count of 0 sets `done` on the next edge with no busy cycle and no strobe.
- R8: A `start` pulse while a transfer is busy is ignored. Count, direction and addresses continue unchanged.
- R9: `done` stays at 1 until the next accepted start or a clear. An accepted start clears it on the next edge.
- R10: While `mclr` is 1, `start` is ignored. If `mclr` is raised during a transfer, the engine drops busy and done on the next edge, and the byte presented in that cycle completes.
- R11: The direction and all setup inputs are sampled only when start is accepted. Changing `dir_up` during a transfer has no effect on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mclr | input | 1 | Master clear; holds the engine idle |
| start | input | 1 | Transfer request, accepted when not busy and not cleared |
| dir_up | input | 1 | 0 = download (disk to RAM), 1 = upload (RAM to disk) |
| head_i | input | 2 | Disk head of the transfer |
| track_i | input | 2 | Disk track of the transfer |
| sector_i | input | 3 | Disk sector of the transfer |
| block_i | input | 4 | First block of the transfer |
| ram_base_i | input | 8 | First RAM address |
| count_i | input | 8 | Number of bytes to move |
| disk_rdata | input | 8 | Byte read from the disk at the current location |
| ram_rdata | input | 8 | Byte read from RAM at the current address |
| disk_head | output | 2 | Current disk head |
| disk_track | output | 2 | Current disk track |
| disk_sector | output | 3 | Current disk sector |
| disk_block | output | 4 | Current disk block |
| disk_rd | output | 1 | Disk read strobe |
| disk_wr | output | 1 | Disk write strobe |
| disk_wdata | output | 8 | Byte written to the disk |
| ram_addr | output | 8 | Current RAM address |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | Byte written to RAM |
| busy_down | output | 1 | Download in progress |
| busy_up | output | 1 | Upload in progress |
| done | output | 1 | Last transfer has completed |

## Verification
A fault in the remaining-byte counter shows at the ports in one of two ways. Busy is held one cycle too long or too short, or `done` rises early. Either is visible within one cycle of the expected end. A stuck or skipped address step shows up in the very next busy cycle as a wrong `disk_block` or `ram_addr`. After the transfer it also leaves a wrong byte in the RAM or disk image. A direction latched at the wrong time swaps the strobe pair at once, and at the end the wrong memory has been modified.

// File: rtl/sector_dma_pkg.sv
package sector_dma_pkg;

    localparam int unsigned HEAD_W   = 2;
    localparam int unsigned TRACK_W  = 2;
    localparam int unsigned SECTOR_W = 3;
    localparam int unsigned BLOCK_W  = 4;
    localparam int unsigned LOC_W    = HEAD_W + TRACK_W + SECTOR_W + BLOCK_W;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_RUN  = 2'd1,
        XF_DONE = 2'd2
    } xfer_state_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic [HEAD_W-1:0]   head;
        logic [TRACK_W-1:0]  track;
        logic [SECTOR_W-1:0] sector;
        logic [BLOCK_W-1:0]  block;
    } disk_loc_t;

    // Advance to the next block; the upper fields are deliberately untouched.
    function automatic disk_loc_t next_block(input disk_loc_t loc);
        disk_loc_t r;
        r       = loc;
        r.block = loc.block + 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
    import sector_dma_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mclr,
    input  logic             start,
    input  logic             dir_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             load_o,
    output logic             step_o,
    output logic             run_dir_o,
    output logic             busy_down_o,
    output logic             busy_up_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    xfer_state_e      state_q;
    xfer_dir_e        dir_q;
    logic [CNT_W-1:0] left_q;

    assign load_o = start && !mclr && (state_q != XF_RUN);
    assign step_o = (state_q == XF_RUN);

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            state_q <= XF_IDLE;
            dir_q   <= DIR_DOWN;
            left_q  <= '0;
        end else if (load_o) begin
            dir_q   <= xfer_dir_e'(dir_i);
            left_q  <= count_i;
            state_q <= (count_i == '0) ? XF_DONE : XF_RUN;
        end else if (state_q == XF_RUN) begin
            left_q <= left_q - CNT_ONE;
            if (left_q == CNT_ONE) begin
                state_q <= XF_DONE;
            end
        end
    end

    assign run_dir_o   = dir_q;
    assign busy_down_o = (state_q == XF_RUN) && (dir_q == DIR_DOWN);
    assign busy_up_o   = (state_q == XF_RUN) && (dir_q == DIR_UP);
    assign done_o      = (state_q == XF_DONE);

    // R4: while more than one byte remains, the run continues and the count drops by one
    a_r4_countdown: assert property (@(posedge clk) disable iff (rst)
        (state_q == XF_RUN && left_q > CNT_ONE && !mclr)
            |=> (state_q == XF_RUN && left_q == $past(left_q) - CNT_ONE));

    // R7: an accepted start with a zero count goes straight to done
    a_r7_zero_count: assert property (@(posedge clk) disable iff (rst)
        (load_o && count_i == '0) |=> (state_q == XF_DONE));

    // R9: done holds until a new start or a clear
    a_r9_done_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == XF_DONE && !start && !mclr) |=> (state_q == XF_DONE));

    // R10: master clear forces idle on the next edge
    a_r10_clear_idle: assert property (@(posedge clk) disable iff (rst)
        mclr |=> (state_q == XF_IDLE));

    // R11: the latched direction never changes mid-run
    a_r11_dir_held: assert property (@(posedge clk) disable iff (rst)
        (state_q == XF_RUN && !mclr) |=> (state_q != XF_RUN || $stable(dir_q)));

endmodule

// File: rtl/sdma_addr_gen.sv
module sdma_addr_gen
    import sector_dma_pkg::*;
#(
    parameter int unsigned RADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic               step_i,
    input  disk_loc_t          loc_i,
    input  logic [RADDR_W-1:0] base_i,
    output disk_loc_t          loc_o,
    output logic [RADDR_W-1:0] raddr_o
);

    localparam logic [RADDR_W-1:0] RADDR_ONE = RADDR_W'(1);

    disk_loc_t          loc_q;
    logic [RADDR_W-1:0] raddr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_q   <= '0;
            raddr_q <= '0;
        end else if (load_i) begin
            loc_q   <= loc_i;
            raddr_q <= base_i;
        end else if (step_i) begin
            loc_q   <= next_block(loc_q);
            raddr_q <= raddr_q + RADDR_ONE;
        end
    end

    assign loc_o   = loc_q;
    assign raddr_o = raddr_q;

    // R5: each step moves the RAM address and the block by one together
    a_r5_lockstep: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> (raddr_q == $past(raddr_q) + RADDR_ONE
                                 && loc_q.block == $past(loc_q.block) + 1'b1));

    // R6: stepping never disturbs head, track or sector
    a_r6_upper_hold: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> ($stable(loc_q.head) && $stable(loc_q.track)
                                 && $stable(loc_q.sector)));

endmodule

// File: rtl/sdma_route.sv
module sdma_route #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              active_i,
    input  logic              up_i,
    input  logic [DATA_W-1:0] disk_rdata_i,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic              disk_rd_o,
    output logic              disk_wr_o,
    output logic              ram_rd_o,
    output logic              ram_wr_o,
    output logic [DATA_W-1:0] disk_wdata_o,
    output logic [DATA_W-1:0] ram_wdata_o
);

    always_comb begin
        disk_rd_o = active_i && !up_i;
        ram_wr_o  = active_i && !up_i;
        ram_rd_o  = active_i &&  up_i;
        disk_wr_o = active_i &&  up_i;
    end

    assign ram_wdata_o  = disk_rdata_i;
    assign disk_wdata_o = ram_rdata_i;

endmodule

// File: rtl/sector_dma.sv
module sector_dma
    import sector_dma_pkg::*;
#(
    parameter int unsigned RADDR_W = 8,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CNT_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mclr,
    input  logic                start,
    input  logic                dir_up,
    input  logic [HEAD_W-1:0]   head_i,
    input  logic [TRACK_W-1:0]  track_i,
    input  logic [SECTOR_W-1:0] sector_i,
    input  logic [BLOCK_W-1:0]  block_i,
    input  logic [RADDR_W-1:0]  ram_base_i,
    input  logic [CNT_W-1:0]    count_i,
    input  logic [DATA_W-1:0]   disk_rdata,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic [HEAD_W-1:0]   disk_head,
    output logic [TRACK_W-1:0]  disk_track,
    output logic [SECTOR_W-1:0] disk_sector,
    output logic [BLOCK_W-1:0]  disk_block,
    output logic                disk_rd,
    output logic                disk_wr,
    output logic [DATA_W-1:0]   disk_wdata,
    output logic [RADDR_W-1:0]  ram_addr,
    output logic                ram_rd,
    output logic                ram_wr,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic                busy_down,
    output logic                busy_up,
    output logic                done
);

    logic      load, step, run_dir;
    disk_loc_t loc_in, loc_cur;

    assign loc_in = '{head: head_i, track: track_i, sector: sector_i, block: block_i};

    sdma_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mclr        (mclr),
        .start       (start),
        .dir_i       (dir_up),
        .count_i     (count_i),
        .load_o      (load),
        .step_o      (step),
        .run_dir_o   (run_dir),
        .busy_down_o (busy_down),
        .busy_up_o   (busy_up),
        .done_o      (done)
    );

    sdma_addr_gen #(.RADDR_W(RADDR_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .step_i  (step),
        .loc_i   (loc_in),
        .base_i  (ram_base_i),
        .loc_o   (loc_cur),
        .raddr_o (ram_addr)
    );

    sdma_route #(.DATA_W(DATA_W)) u_route (
        .active_i     (step),
        .up_i         (run_dir),
        .disk_rdata_i (disk_rdata),
        .ram_rdata_i  (ram_rdata),
        .disk_rd_o    (disk_rd),
        .disk_wr_o    (disk_wr),
        .ram_rd_o     (ram_rd),
        .ram_wr_o     (ram_wr),
        .disk_wdata_o (disk_wdata),
        .ram_wdata_o  (ram_wdata)
    );

    assign disk_head   = loc_cur.head;
    assign disk_track  = loc_cur.track;
    assign disk_sector = loc_cur.sector;
    assign disk_block  = loc_cur.block;

    // R2: RAM is written only during a download
    a_r2_ram_wr_in_down: assert property (@(posedge clk) disable iff (rst)
        ram_wr |-> busy_down);

    // R3: the disk is written only during an upload
    a_r3_disk_wr_in_up: assert property (@(posedge clk) disable iff (rst)
        disk_wr |-> busy_up);

    // R4: the end of a normal run raises done on the same edge
    a_r4_busy_to_done: assert property (@(posedge clk) disable iff (rst)
        ((busy_down || busy_up) && !mclr)
            |=> (busy_down || busy_up || done));

endmodule

// File: tb/sim_sector_dma.sv
module sim_sector_dma;
    import sector_dma_pkg::*;

    typedef struct packed {
        logic [1:0] h;
        logic [1:0] t;
        logic [2:0] s;
        logic [3:0] b;
        logic [7:0] base;
        logic [7:0] cnt;
        logic       up;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{h: 2'd1, t: 2'd2, s: 3'd3, b: 4'd4,  base: 8'hAB, cnt: 8'd6,  up: 1'b0},
        '{h: 2'd2, t: 2'd3, s: 3'd4, b: 4'd5,  base: 8'hAC, cnt: 8'd2,  up: 1'b1},
        '{h: 2'd0, t: 2'd1, s: 3'd5, b: 4'd14, base: 8'hFE, cnt: 8'd5,  up: 1'b0},
        '{h: 2'd3, t: 2'd0, s: 3'd7, b: 4'd0,  base: 8'h10, cnt: 8'd16, up: 1'b1},
        '{h: 2'd1, t: 2'd1, s: 3'd1, b: 4'd9,  base: 8'h40, cnt: 8'd20, up: 1'b0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, mclr, start, dir_up;
    logic [1:0] head_i, track_i;
    logic [2:0] sector_i;
    logic [3:0] block_i;
    logic [7:0] ram_base_i, count_i;
    logic [7:0] disk_rdata, ram_rdata, disk_wdata, ram_wdata, ram_addr;
    logic [1:0] disk_head, disk_track;
    logic [2:0] disk_sector;
    logic [3:0] disk_block;
    logic disk_rd, disk_wr, ram_rd, ram_wr, busy_down, busy_up, done;

    logic [7:0] disk_mem [2048];
    logic [7:0] ram_mem  [256];
    logic [7:0] exp_disk [2048];
    logic [7:0] exp_ram  [256];

    int total = 0;
    int fails = 0;

    sector_dma u0 (
        .clk(clk), .rst(rst), .mclr(mclr), .start(start), .dir_up(dir_up),
        .head_i(head_i), .track_i(track_i), .sector_i(sector_i), .block_i(block_i),
        .ram_base_i(ram_base_i), .count_i(count_i),
        .disk_rdata(disk_rdata), .ram_rdata(ram_rdata),
        .disk_head(disk_head), .disk_track(disk_track), .disk_sector(disk_sector),
        .disk_block(disk_block), .disk_rd(disk_rd), .disk_wr(disk_wr),
        .disk_wdata(disk_wdata), .ram_addr(ram_addr), .ram_rd(ram_rd),
        .ram_wr(ram_wr), .ram_wdata(ram_wdata),
        .busy_down(busy_down), .busy_up(busy_up), .done(done)
    );

    // storage models
    assign disk_rdata = disk_mem[{disk_head, disk_track, disk_sector, disk_block}];
    assign ram_rdata  = ram_mem[ram_addr];
    always @(posedge clk) begin
        if (disk_wr) disk_mem[{disk_head, disk_track, disk_sector, disk_block}] <= disk_wdata;
        if (ram_wr)  ram_mem[ram_addr] <= ram_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic chk_images(input string req);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < 256; a++)
            if (ram_mem[a] !== exp_ram[a]) begin bad++; if (first < 0) first = a; end
        for (int a = 0; a < 2048; a++)
            if (disk_mem[a] !== exp_disk[a]) begin bad++; if (first < 0) first = 1000 + a; end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic drive_setup(input vec_t v);
        head_i = v.h; track_i = v.t; sector_i = v.s; block_i = v.b;
        ram_base_i = v.base; count_i = v.cnt; dir_up = v.up;
    endtask

    // poke: pulse start with other settings in the second busy cycle (R8, R11)
    task automatic run_xfer(input vec_t v, input bit poke);
        logic [3:0]  blk;
        logic [7:0]  ra;
        logic [10:0] di;
        @(negedge clk);
        drive_setup(v);
        start = 1'b1;
        for (int i = 0; i < int'(v.cnt); i++) begin
            @(negedge clk);
            if (i == 0) begin
                start = 1'b0;
                chk(done == 1'b0, "R9 done cleared by start", done, 0);
                chk((v.up ? busy_up : busy_down) == 1'b1 &&
                    (v.up ? busy_down : busy_up) == 1'b0,
                    "R4 busy of selected direction", {busy_up, busy_down}, v.up ? 2 : 1);
            end
            if (poke && i == 1) begin
                start = 1'b1; count_i = 8'd1; dir_up = ~v.up;
                block_i = 4'd0; ram_base_i = 8'h00; head_i = ~v.h;
            end
            if (poke && i == 2) start = 1'b0;
            blk = v.b + 4'(i);
            ra  = v.base + 8'(i);
            chk(disk_block == blk && ram_addr == ra, "R5 block and RAM address step",
                {disk_block, ram_addr}, {blk, ra});
            chk(disk_head == v.h && disk_track == v.t && disk_sector == v.s,
                "R6 upper fields held", {disk_head, disk_track, disk_sector}, {v.h, v.t, v.s});
            if (v.up)
                chk(ram_rd && disk_wr && !disk_rd && !ram_wr, "R3 upload strobes R11",
                    {disk_rd, disk_wr, ram_rd, ram_wr}, 4'b0110);
            else
                chk(disk_rd && ram_wr && !disk_wr && !ram_rd, "R2 download strobes R11",
                    {disk_rd, disk_wr, ram_rd, ram_wr}, 4'b1001);
            di = {v.h, v.t, v.s, blk};
            if (v.up) exp_disk[di] = exp_ram[ra];
            else      exp_ram[ra]  = exp_disk[di];
        end
        @(negedge clk);
        start = 1'b0;
        chk(!busy_down && !busy_up && done, "R4 end: busy falls, done rises",
            {busy_down, busy_up, done}, 1);
        chk_images(v.up ? "R3 disk image after upload" : "R2 RAM image after download");
    endtask

    initial begin
        rst = 1'b1; mclr = 1'b0; start = 1'b0;
        drive_setup('0);
        for (int a = 0; a < 2048; a++) begin
            disk_mem[a] = 8'(a * 37 + 11); exp_disk[a] = 8'(a * 37 + 11);
        end
        for (int a = 0; a < 256; a++) begin
            ram_mem[a] = 8'(a) ^ 8'h5A; exp_ram[a] = 8'(a) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        chk(!busy_down && !busy_up && !done && !disk_rd && !disk_wr && !ram_rd && !ram_wr,
            "R1 reset state", {busy_down, busy_up, done, disk_rd, disk_wr, ram_rd, ram_wr}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_down && !busy_up && !done, "R1 first cycle after reset",
            {busy_down, busy_up, done}, 0);

        // table walk (R2, R3, R5, R6 including block and RAM wrap)
        for (int k = 0; k < NVEC; k++) run_xfer(VECS[k], 1'b0);

        // R9: done holds with no start
        repeat (5) @(negedge clk);
        chk(done && !busy_down && !busy_up, "R9 done held", done, 1);

        // R7: zero count
        @(negedge clk);
        drive_setup('{h: 2'd0, t: 2'd0, s: 3'd0, b: 4'd3, base: 8'h20, cnt: 8'd0, up: 1'b0});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy_down && !busy_up && !disk_rd && !ram_wr && !disk_wr && !ram_rd,
            "R7 zero count", {done, busy_down, busy_up, disk_rd, ram_wr}, 5'b10000);
        chk_images("R7 no memory change");

        // R8 and R11: start pulse with other settings during a busy run
        run_xfer('{h: 2'd2, t: 2'd1, s: 3'd6, b: 4'd12, base: 8'h80, cnt: 8'd6, up: 1'b1}, 1'b1);

        // R10: start ignored while cleared, and clear removes done
        @(negedge clk);
        mclr = 1'b1;
        drive_setup('{h: 2'd0, t: 2'd2, s: 3'd2, b: 4'd1, base: 8'h60, cnt: 8'd4, up: 1'b0});
        start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(!busy_down && !busy_up && !done && !ram_wr && !disk_rd,
            "R10 start ignored under clear", {busy_down, busy_up, done}, 0);
        mclr = 1'b0;

        // R10: clear during a run, byte presented in that cycle completes
        @(negedge clk);
        drive_setup('{h: 2'd3, t: 2'd3, s: 3'd2, b: 4'd7, base: 8'hC0, cnt: 8'd8, up: 1'b0});
        start = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            start = 1'b0;
            exp_ram[8'hC0 + 8'(i)] = exp_disk[{2'd3, 2'd3, 3'd2, 4'd7 + 4'(i)}];
        end
        mclr = 1'b1;
        @(negedge clk);
        chk(!busy_down && !busy_up && !done && !ram_wr, "R10 clear aborts run",
            {busy_down, busy_up, done, ram_wr}, 0);
        mclr = 1'b0;
        @(negedge clk);
        chk_images("R10 image after abort");

        // R10: engine restarts after clear is released
        run_xfer('{h: 2'd0, t: 2'd3, s: 3'd0, b: 4'd2, base: 8'h05, cnt: 8'd3, up: 1'b1}, 1'b0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule